// File: doc/BRIEF.md
# Port Input Address and Extend Unit

This unit runs the port-input operation of a processor pipeline for 8-bit and 16-bit transfers. It takes a 32-bit base value from the register file, a signed 16-bit offset, a size select and a one-cycle start strobe. From these it forms the port address. It then runs one read on a simple request/acknowledge port bus and returns a zero-extended 32-bit result for writeback.

The address is the base plus the sign-extended offset, and the sum wraps modulo 2^32. The unit produces no carry and no overflow, and it leaves the processor's condition flags alone. For a 16-bit transfer the lowest address bit is cleared before the request goes out. The request stays on the bus until the port acknowledges it, so the port can insert any number of wait cycles. The returned lane is chosen from the 32-bit port data word by the low address bits, with byte 0 in data bits 7:0. The result is valid for one cycle, the cycle after the acknowledge.

Top module: `port_rd_engine`

## Requirements
- R1: The port address equals the base plus the offset sign-extended to 32 bits, taken modulo 2^32, so it can wrap in either direction.
- R2: When the size select is 1 (16-bit), address bit 0 is driven to 0 on the port bus. When the size select is 0 (8-bit), the unit does not alter the sum.
- R3: The request appears on the cycle after an accepted start. Address and size code stay stable while the request is high and the acknowledge is low, for any number of wait cycles.
- R4: For an 8-bit read, result bits 7:0 come from data lane address[1:0] (lane n is data bits 8n+7:8n), and result bits 31:8 are zero.
- R5: For a 16-bit read, result bits 15:0 come from data bits 31:16 when address bit 1 is 1 and from bits 15:0 otherwise. Result bits 31:16 are zero.
- R6: The writeback-valid output is high for exactly one cycle, the cycle after the acknowledge is sampled with the request high. The writeback data is valid in that same cycle.
- R7: A start that arrives while busy is high is ignored. The pending address and size are unchanged, and only one writeback pulse follows.
- R8: While reset is high, and on the cycle after it, request, writeback-valid and busy are all low. A reset in the middle of a transfer drops the request.
- R9: The size code on the port bus is 0 for an 8-bit transfer and 1 for a 16-bit transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, accepted when idle |
| base_i | input | 32 | Base register value |
| disp_i | input | 16 | Signed offset |
| size_i | input | 1 | 0 = 8-bit, 1 = 16-bit |
| busy_o | output | 1 | Transfer in progress |
| preq_o | output | 1 | Port read request |
| paddr_o | output | 32 | Port address |
| psize_o | output | 1 | Port size code |
| pack_i | input | 1 | Port acknowledge |
| prdata_i | input | 32 | Port read data |
| wb_valid_o | output | 1 | Writeback valid pulse |
| wb_data_o | output | 32 | Zero-extended result |

## Verification
The checker watches every cycle for four things. The request must hold with a steady address and size through wait cycles. A 16-bit request must have an even address. The writeback pulse must come only from an acknowledged request, last exactly one cycle, and carry zero upper bits for its size. Reset must clear the bus and writeback outputs. The arithmetic is checked only by the bench's scenarios: the wrapped and sign-extended sums, which lane each address selects, and how a start during a transfer is rejected.

// File: rtl/port_rd_pkg.sv
package port_rd_pkg;
  typedef enum logic [0:0] {
    SZ_BYTE = 1'b0,
    SZ_HALF = 1'b1
  } xfer_size_e;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } seq_state_e;
endpackage

// File: rtl/prd_addr_gen.sv
// Effective address: base + sign-extended offset, wraps silently.
module prd_addr_gen
  import port_rd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DISP_W-1:0] disp_i,
  input  xfer_size_e        size_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] sum;

  always_comb begin
    disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
    sum      = base_i + disp_ext;
    if (size_i == SZ_HALF) addr_o = {sum[ADDR_W-1:1], 1'b0};
    else                   addr_o = sum;
  end
endmodule

// File: rtl/prd_bus_seq.sv
// Holds the port request registered until acknowledged.
module prd_bus_seq
  import port_rd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  xfer_size_e        size_i,
  input  logic              pack_i,
  output logic              busy_o,
  output logic              preq_o,
  output logic [ADDR_W-1:0] paddr_o,
  output xfer_size_e        psize_o,
  output logic              ack_fire_o
);
  seq_state_e state_q;

  assign busy_o     = (state_q == ST_WAIT);
  assign ack_fire_o = preq_o & pack_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      preq_o  <= 1'b0;
      paddr_o <= '0;
      psize_o <= SZ_BYTE;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_WAIT;
            preq_o  <= 1'b1;
            paddr_o <= addr_i;
            psize_o <= size_i;
          end
        end
        ST_WAIT: begin
          if (pack_i) begin
            state_q <= ST_IDLE;
            preq_o  <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/prd_lane_pick.sv
// Selects the addressed byte or halfword lane and zero-extends it.
module prd_lane_pick
  import port_rd_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int SEL_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  xfer_size_e        size_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int HALVES = LANES / 2;

  logic [7:0]  byte_lane [LANES];
  logic [15:0] half_lane [HALVES];

  for (genvar g = 0; g < LANES; g++) begin : g_byte
    assign byte_lane[g] = rdata_i[8*g +: 8];
  end
  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign half_lane[h] = rdata_i[16*h +: 16];
  end

  always_comb begin
    data_o = '0;
    if (size_i == SZ_HALF) data_o[15:0] = half_lane[sel_i[SEL_W-1:1]];
    else                   data_o[7:0]  = byte_lane[sel_i];
  end
endmodule

// File: rtl/port_rd_engine.sv
module port_rd_engine
  import port_rd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic              size_i,
  output logic              busy_o,
  output logic              preq_o,
  output logic [ADDR_W-1:0] paddr_o,
  output logic              psize_o,
  input  logic              pack_i,
  input  logic [DATA_W-1:0] prdata_i,
  output logic              wb_valid_o,
  output logic [DATA_W-1:0] wb_data_o
);
  localparam int SEL_W = $clog2(DATA_W / 8);

  xfer_size_e        size_in;
  xfer_size_e        size_q;
  logic [ADDR_W-1:0] eff_addr;
  logic              ack_fire;
  logic [DATA_W-1:0] picked;

  assign size_in = xfer_size_e'(size_i);
  assign psize_o = size_q;

  prd_addr_gen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_addr (
    .base_i (base_i),
    .disp_i (disp_i),
    .size_i (size_in),
    .addr_o (eff_addr)
  );

  prd_bus_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .addr_i     (eff_addr),
    .size_i     (size_in),
    .pack_i     (pack_i),
    .busy_o     (busy_o),
    .preq_o     (preq_o),
    .paddr_o    (paddr_o),
    .psize_o    (size_q),
    .ack_fire_o (ack_fire)
  );

  prd_lane_pick #(.DATA_W(DATA_W)) u_pick (
    .rdata_i (prdata_i),
    .sel_i   (paddr_o[SEL_W-1:0]),
    .size_i  (size_q),
    .data_o  (picked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid_o <= 1'b0;
      wb_data_o  <= '0;
    end else begin
      wb_valid_o <= ack_fire;
      if (ack_fire) wb_data_o <= picked;
    end
  end
endmodule

// File: rtl/port_rd_checker.sv
module port_rd_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              preq_o,
  input logic [ADDR_W-1:0] paddr_o,
  input logic              psize_o,
  input logic              pack_i,
  input logic              wb_valid_o,
  input logic [DATA_W-1:0] wb_data_o
);
  a_r3_hold_request: assert property (@(posedge clk) disable iff (rst)
    (preq_o && !pack_i) |=> (preq_o && $stable(paddr_o) && $stable(psize_o)));

  a_r2_half_even: assert property (@(posedge clk) disable iff (rst)
    (preq_o && psize_o) |-> !paddr_o[0]);

  a_r6_wb_after_ack: assert property (@(posedge clk) disable iff (rst)
    (preq_o && pack_i) |=> wb_valid_o);

  a_r6_wb_from_ack: assert property (@(posedge clk) disable iff (rst)
    wb_valid_o |-> $past(preq_o && pack_i));

  a_r6_wb_single: assert property (@(posedge clk) disable iff (rst)
    wb_valid_o |=> !wb_valid_o);

  a_r4_byte_zext: assert property (@(posedge clk) disable iff (rst)
    (wb_valid_o && !$past(psize_o)) |-> (wb_data_o[DATA_W-1:8] == '0));

  a_r5_half_zext: assert property (@(posedge clk) disable iff (rst)
    (wb_valid_o && $past(psize_o)) |-> (wb_data_o[DATA_W-1:16] == '0));

  a_r8_reset_clear: assert property (@(posedge clk)
    rst |=> (!preq_o && !wb_valid_o));
endmodule

bind port_rd_engine port_rd_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .preq_o     (preq_o),
  .paddr_o    (paddr_o),
  .psize_o    (psize_o),
  .pack_i     (pack_i),
  .wb_valid_o (wb_valid_o),
  .wb_data_o  (wb_data_o)
);

// File: tb/test_port_rd_engine.sv
`timescale 1ns/1ps
module test_port_rd_engine;
  typedef struct packed {
    logic [31:0] base;
    logic [15:0] disp;
    logic        size;
    logic [3:0]  waits;
    logic [31:0] rdata;
    logic [31:0] exp_addr;
    logic [31:0] exp_data;
  } vec_t;

  // size 0 = 8-bit, 1 = 16-bit
  localparam vec_t VECS [0:8] = '{
    '{32'h0000_1000, 16'h0004, 1'b0, 4'd0, 32'h4433_2211, 32'h0000_1004, 32'h0000_0011},
    '{32'h0000_1000, 16'hFFFF, 1'b0, 4'd2, 32'hA1B2_C3D4, 32'h0000_0FFF, 32'h0000_00A1},
    '{32'h0000_0000, 16'h8000, 1'b0, 4'd1, 32'h0000_80FE, 32'hFFFF_8000, 32'h0000_00FE},
    '{32'hFFFF_FFF0, 16'h0012, 1'b0, 4'd0, 32'h00FF_0000, 32'h0000_0002, 32'h0000_00FF},
    '{32'h0000_0100, 16'h0001, 1'b0, 4'd0, 32'h0000_BB00, 32'h0000_0101, 32'h0000_00BB},
    '{32'h0000_2001, 16'h0000, 1'b1, 4'd0, 32'h8765_CAFE, 32'h0000_2000, 32'h0000_CAFE},
    '{32'h0000_2002, 16'h0001, 1'b1, 4'd3, 32'hBEEF_1234, 32'h0000_2002, 32'h0000_BEEF},
    '{32'h7FFF_FFFF, 16'h7FFF, 1'b1, 4'd1, 32'hF00D_0000, 32'h8000_7FFE, 32'h0000_F00D},
    '{32'h0000_0010, 16'hFFF1, 1'b1, 4'd0, 32'h5555_AAAA, 32'h0000_0000, 32'h0000_AAAA}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] base_i = '0;
  logic [15:0] disp_i = '0;
  logic        size_i = 1'b0;
  logic        pack_i = 1'b0;
  logic [31:0] prdata_i = '0;
  logic        busy_o, preq_o, psize_o, wb_valid_o;
  logic [31:0] paddr_o, wb_data_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  port_rd_engine i_port_rd_engine (
    .clk(clk), .rst(rst), .start_i(start_i), .base_i(base_i), .disp_i(disp_i),
    .size_i(size_i), .busy_o(busy_o), .preq_o(preq_o), .paddr_o(paddr_o),
    .psize_o(psize_o), .pack_i(pack_i), .prdata_i(prdata_i),
    .wb_valid_o(wb_valid_o), .wb_data_o(wb_data_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input string tag);
    @(negedge clk);
    start_i = 1'b1; base_i = v.base; disp_i = v.disp; size_i = v.size;
    @(negedge clk);
    start_i = 1'b0;
    chk({tag, " R3 request"}, {31'd0, preq_o}, 32'd1);
    chk({tag, " R1/R2 address"}, paddr_o, v.exp_addr);
    chk({tag, " R9 size code"}, {31'd0, psize_o}, {31'd0, v.size});
    for (int w = 0; w < int'(v.waits); w++) begin
      @(negedge clk);
      chk({tag, " R3 wait hold addr"}, paddr_o, v.exp_addr);
      chk({tag, " R3 wait hold req"}, {31'd0, preq_o}, 32'd1);
      chk({tag, " R6 no early wb"}, {31'd0, wb_valid_o}, 32'd0);
    end
    pack_i = 1'b1; prdata_i = v.rdata;
    @(negedge clk);
    pack_i = 1'b0; prdata_i = '0;
    chk({tag, " R6 wb pulse"}, {31'd0, wb_valid_o}, 32'd1);
    chk({tag, v.size ? " R5 half data" : " R4 byte data"}, wb_data_o, v.exp_data);
    chk({tag, " R3 request dropped"}, {31'd0, preq_o}, 32'd0);
    @(negedge clk);
    chk({tag, " R6 wb single"}, {31'd0, wb_valid_o}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset req", {31'd0, preq_o}, 32'd0);
    chk("R8 reset wb", {31'd0, wb_valid_o}, 32'd0);
    chk("R8 reset busy", {31'd0, busy_o}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 after reset req", {31'd0, preq_o}, 32'd0);

    for (int i = 0; i < 9; i++) run_vec(VECS[i], $sformatf("vec%0d", i));

    // R7: start during an outstanding request is ignored
    @(negedge clk);
    start_i = 1'b1; base_i = 32'h0000_0040; disp_i = 16'h0003; size_i = 1'b0;
    @(negedge clk);
    base_i = 32'h0000_9000; disp_i = 16'h0000; size_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R7 addr kept", paddr_o, 32'h0000_0043);
    chk("R7 size kept", {31'd0, psize_o}, 32'd0);
    chk("R7 busy", {31'd0, busy_o}, 32'd1);
    pack_i = 1'b1; prdata_i = 32'h7700_0000;
    @(negedge clk);
    pack_i = 1'b0;
    chk("R7 R4 data lane3", wb_data_o, 32'h0000_0077);
    @(negedge clk);
    chk("R7 no second request", {31'd0, preq_o}, 32'd0);
    chk("R7 no second wb", {31'd0, wb_valid_o}, 32'd0);

    // R8: reset in the middle of a transfer
    start_i = 1'b1; base_i = 32'h0000_0200; disp_i = 16'h0000; size_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R8 pre-reset req", {31'd0, preq_o}, 32'd1);
    rst = 1'b1;
    @(negedge clk);
    chk("R8 mid reset req", {31'd0, preq_o}, 32'd0);
    chk("R8 mid reset busy", {31'd0, busy_o}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 idle after reset", {31'd0, wb_valid_o}, 32'd0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule